// File: doc/BRIEF.md
# Half-Precision Floating-Point Multiplier

This block multiplies two IEEE 754 binary16 operands and returns their binary16 product, rounded to nearest with ties going to the even neighbour. It is intended as a datapath leaf inside a larger arithmetic unit. Operands are applied on two 16-bit inputs and the product appears on one 16-bit output. By default the product is captured in an output register, so it is valid one clock after the operands. A parameter removes that register and leaves a purely combinational path.

Special operands are resolved before any arithmetic. A NaN on either input is returned in quieted form with its payload kept, and operand A takes precedence over operand B. Zero times infinity gives the default quiet NaN. Infinite or zero operands give a signed infinity or a signed zero.

Finite non-zero operands go through the arithmetic path. Their 11-bit significands are multiplied into a 22-bit product, which is normalized with a leading-zero count. A product whose exponent falls below the normal range is shifted back right with sticky collection, so that gradual underflow rounds correctly. Only one rounding mode exists, and no exception flags are produced.

Top module: `hmul16_core`

## Requirements
- R1: When operand A is a NaN (exponent field bits [14:10] all ones, fraction bits [9:0] non-zero), the result keeps A's sign and fraction, with the exponent field all ones and fraction bit 9 forced to 1.
- R2: When A is not a NaN and B is a NaN, the result is B quieted in the same way as R1.
- R3: A zero multiplied by an infinity, in either order and with any signs, returns 16'h7E00, provided neither operand is a NaN.
- R4: Otherwise, if either operand is infinite, the result is infinity (exponent all ones, fraction zero), with its sign bit 15 equal to the XOR of the operand signs.
- R5: Otherwise, if either operand is zero, the result is a zero whose sign is the XOR of the operand signs.
- R6: For finite non-zero operands whose product lies in the normal range, the result is the exact product rounded to nearest. A product exactly halfway between two neighbours rounds to the one with an even fraction.
- R7: A rounded product whose magnitude exceeds the largest finite value (16'h7BFF) gives infinity of the proper sign. This includes products that overflow only because they are rounded up.
- R8: Products below the smallest normal magnitude give subnormal results (exponent field 0), rounded to nearest-even in units of 2^-24. A value that rounds up to 2^-14 gives the smallest normal, 16'h0400 with the proper sign.
- R9: Subnormal inputs (exponent field 0, non-zero fraction) take part with a significand of 0.fraction and an exponent of -14, and can produce normal results.
- R10: With the output register enabled, a synchronous active-low reset clears the result to 16'h0000. The result for a pair of operands appears after the next rising clock edge, and not before it.
- R11: Products far below the smallest subnormal round to a zero of the proper sign. A product equal to exactly half of 2^-24 ties to zero, and a product just above that half gives the smallest subnormal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset of the output register |
| op_a | input | 16 | Operand A in binary16 encoding |
| op_b | input | 16 | Operand B in binary16 encoding |
| result | output | 16 | Rounded binary16 product |

## Verification
Directed pairs pin each special-value rule. NaN pairs with both operands NaN tell the A-over-B precedence apart from a plain OR of the inputs. Known halfway products separate ties-to-even from round-half-up, both in the normal range and at subnormal scale. Operands just above and below the overflow and underflow limits tell apart the re-shift with sticky collection, the round-up into the smallest normal and the round-up into infinity. A large body of random pairs is weighted towards subnormal, tiny, huge and special exponents and is compared against an exact-integer model. That model finds the rounding position directly from the magnitude, without normalizing first.

// File: rtl/hmul16_pkg.sv
// hmul16_pkg: field widths, derived constants and the decoded-operand type
// shared by the binary16 multiplier. Assumes a binary16-style layout of
// sign, biased exponent and fraction, most significant first.
package hmul16_pkg;
    localparam int EXP_W  = 5;
    localparam int MAN_W  = 10;
    localparam int SIG_W  = MAN_W + 1;
    localparam int PROD_W = 2 * SIG_W;
    localparam int WORD_W = 1 + EXP_W + MAN_W;
    localparam int SEXP_W = 8;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int EMIN   = 1 - BIAS;
    localparam int EMAX   = BIAS;
    localparam int PAD_W  = 1 << $clog2(PROD_W);
    localparam int LZ_W   = $clog2(PAD_W);

    // Decoded view of one operand
    typedef struct packed {
        logic              sign;
        logic              is_nan;
        logic              is_inf;
        logic              is_zero;
        logic [SIG_W-1:0]  sig;
        logic [SEXP_W-1:0] uexp;   // two's-complement unbiased exponent
    } opnd_t;
endpackage

// File: rtl/hmul16_unpack.sv
// hmul16_unpack: splits a binary16 word into sign, class flags, significand
// with hidden bit, and a two's-complement unbiased exponent. Subnormals get
// the minimum exponent and a zero hidden bit. Purely combinational.
module hmul16_unpack
    import hmul16_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output opnd_t             info_o
);
    logic [EXP_W-1:0] efield;
    logic [MAN_W-1:0] ffield;
    logic             e_ones;
    logic             e_zero;

    assign efield = word_i[WORD_W-2 -: EXP_W];
    assign ffield = word_i[MAN_W-1:0];
    assign e_ones = &efield;
    assign e_zero = ~|efield;

    // Classify the operand and build significand and exponent
    always_comb begin
        info_o.sign    = word_i[WORD_W-1];
        info_o.is_nan  = e_ones && (ffield != '0);
        info_o.is_inf  = e_ones && (ffield == '0);
        info_o.is_zero = e_zero && (ffield == '0);
        info_o.sig     = {~e_zero, ffield};
        info_o.uexp    = e_zero ? SEXP_W'(EMIN)
                                : SEXP_W'(efield) - SEXP_W'(BIAS);
    end
endmodule

// File: rtl/hmul16_lzc.sv
// hmul16_lzc: leading-zero count by repeated halving. The input is left
// aligned into a power-of-two width with zero padding. Each stage tests the
// upper half of the remaining window and shifts it away when it is all zero.
// The last stage's top bits are the input shifted left by its count.
// Assumes a non-zero input wherever the count is consumed.
module hmul16_lzc #(
    parameter int IN_W = 22
) (
    input  logic [IN_W-1:0]             val_i,
    output logic [$clog2(IN_W)-1:0]     cnt_o,
    output logic [(1<<$clog2(IN_W))-1:0] norm_o
);
    localparam int PW = 1 << $clog2(IN_W);
    localparam int CW = $clog2(PW);

    logic [PW-1:0] stage [CW+1];
    logic [CW-1:0] cnt;

    assign stage[0] = PW'(val_i) << (PW - IN_W);

    // One halving step per count bit, widest first
    for (genvar k = 0; k < CW; k++) begin : g_half
        localparam int SH = 1 << (CW - 1 - k);
        logic upper_zero;
        assign upper_zero     = ~|stage[k][PW-1 -: SH];
        assign cnt[CW-1-k]    = upper_zero;
        assign stage[k+1]     = upper_zero ? (stage[k] << SH) : stage[k];
    end

    assign cnt_o  = cnt;
    assign norm_o = stage[CW];
endmodule

// File: rtl/hmul16_sticky_rshift.sv
// hmul16_sticky_rshift: logical right shift whose lost bits are ORed into
// bit 0. Shifts of the full width or more leave only the sticky bit, which
// is set when the input was non-zero. The amount is treated as unsigned.
module hmul16_sticky_rshift #(
    parameter int W    = 22,
    parameter int AMTW = 8
) (
    input  logic [W-1:0]    din_i,
    input  logic [AMTW-1:0] amt_i,
    output logic [W-1:0]    dout_o
);
    logic [W-1:0] lost_mask;
    logic         lost_any;

    // Shift with sticky collection, saturating at the full width
    always_comb begin
        lost_mask = '0;
        lost_any  = 1'b0;
        if (amt_i >= AMTW'(W)) begin
            dout_o = {{(W-1){1'b0}}, |din_i};
        end else begin
            lost_mask = ~({W{1'b1}} << amt_i);
            lost_any  = |(din_i & lost_mask);
            dout_o    = (din_i >> amt_i) | {{(W-1){1'b0}}, lost_any};
        end
    end
endmodule

// File: rtl/hmul16_round.sv
// hmul16_round: rounds a 22-bit significand to nearest, ties to even, and
// packs the result. The fraction is taken from bits 20:11 and bits 10:0 are
// the discarded part. A carry out renormalizes and bumps the exponent. A
// subnormal that rounds into bit 21 is promoted to exponent field 1.
// Exponents above the maximum give infinity.
module hmul16_round
    import hmul16_pkg::*;
(
    input  logic              sign_i,
    input  logic [PROD_W-1:0] frac_i,
    input  logic [SEXP_W-1:0] exp_i,
    input  logic [EXP_W-1:0]  field_i,
    output logic [WORD_W-1:0] word_o
);
    localparam logic [MAN_W:0] HALF = {1'b1, {MAN_W{1'b0}}};
    localparam logic [SEXP_W-1:0] OVF_EXP = SEXP_W'(EMAX + 1);

    logic [MAN_W:0]    tail;
    logic              tie;
    logic              inc;
    logic [PROD_W:0]   bumped;
    logic [PROD_W-1:0] frac_r;
    logic [SEXP_W-1:0] exp_r;
    logic [EXP_W-1:0]  field_r;

    assign tail   = frac_i[MAN_W:0];
    assign tie    = (tail == HALF);
    assign inc    = tie ? frac_i[MAN_W+1] : (tail > HALF);
    assign bumped = {1'b0, frac_i} + (PROD_W+1)'(HALF);

    // Apply the increment and renormalize on carry out
    always_comb begin
        frac_r  = frac_i;
        exp_r   = exp_i;
        field_r = field_i;
        if (inc && bumped[PROD_W]) begin
            frac_r  = {1'b1, bumped[PROD_W-1:1]};
            exp_r   = exp_i + SEXP_W'(1);
            field_r = field_i + EXP_W'(1);
        end else if (inc) begin
            frac_r  = bumped[PROD_W-1:0];
        end
    end

    // Pack the word, promoting subnormals and saturating to infinity
    always_comb begin
        if ($signed(exp_r) >= $signed(OVF_EXP)) begin
            word_o = {sign_i, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
        end else if ((field_r == '0) && frac_r[PROD_W-1]) begin
            word_o = {sign_i, EXP_W'(1), frac_r[PROD_W-2 -: MAN_W]};
        end else begin
            word_o = {sign_i, field_r, frac_r[PROD_W-2 -: MAN_W]};
        end
    end
endmodule

// File: rtl/hmul16_core.sv
// hmul16_core: binary16 multiplier with round to nearest, ties to even.
// Special operands are resolved first: a NaN in A, then a NaN in B, then
// zero times infinity, then infinity, then zero. Finite products are
// normalized with a leading-zero count. Products below the normal range are
// shifted back right with sticky collection before rounding. OUT_REG selects
// a registered output (synchronous active-low reset) or a combinational one.
module hmul16_core
    import hmul16_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    output logic [WORD_W-1:0] result
);
    localparam logic [SEXP_W-1:0] EMIN_S   = SEXP_W'(EMIN);
    localparam logic [WORD_W-1:0] DFLT_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

    opnd_t             ua;
    opnd_t             ub;
    logic              psign;
    logic [PROD_W-1:0] prod;
    logic [LZ_W-1:0]   lz;
    logic [PAD_W-1:0]  norm_pad;
    logic [PROD_W-1:0] norm;
    logic [SEXP_W-1:0] nexp;
    logic [SEXP_W-1:0] dshift;
    logic              to_sub;
    logic [PROD_W-1:0] denorm;
    logic [PROD_W-1:0] rfrac;
    logic [SEXP_W-1:0] rexp;
    logic [EXP_W-1:0]  rfield;
    logic [WORD_W-1:0] fin_word;
    logic [WORD_W-1:0] res_c;

    hmul16_unpack u_unpack_a (.word_i(op_a), .info_o(ua));
    hmul16_unpack u_unpack_b (.word_i(op_b), .info_o(ub));

    assign psign = ua.sign ^ ub.sign;
    assign prod  = PROD_W'(ua.sig) * PROD_W'(ub.sig);

    hmul16_lzc #(.IN_W(PROD_W)) u_lzc (
        .val_i  (prod),
        .cnt_o  (lz),
        .norm_o (norm_pad)
    );
    assign norm = norm_pad[PAD_W-1 -: PROD_W];

    // Exponent of the normalized product and distance below the normal range
    always_comb begin
        nexp   = ua.uexp + ub.uexp + SEXP_W'(1) - SEXP_W'(lz);
        dshift = EMIN_S - nexp;
        to_sub = $signed(dshift) > $signed(SEXP_W'(0));
    end

    hmul16_sticky_rshift #(.W(PROD_W), .AMTW(SEXP_W)) u_denorm (
        .din_i  (norm),
        .amt_i  (dshift),
        .dout_o (denorm)
    );

    // Choose the normal or the gradual-underflow operands for rounding
    always_comb begin
        if (to_sub) begin
            rfrac  = denorm;
            rexp   = EMIN_S;
            rfield = '0;
        end else begin
            rfrac  = norm;
            rexp   = nexp;
            rfield = nexp[EXP_W-1:0] + EXP_W'(BIAS);
        end
    end

    hmul16_round u_round (
        .sign_i  (psign),
        .frac_i  (rfrac),
        .exp_i   (rexp),
        .field_i (rfield),
        .word_o  (fin_word)
    );

    // Special-operand priority ahead of the arithmetic result
    always_comb begin
        if (ua.is_nan) begin
            res_c = {op_a[WORD_W-1], {EXP_W{1'b1}}, 1'b1, op_a[MAN_W-2:0]};
        end else if (ub.is_nan) begin
            res_c = {op_b[WORD_W-1], {EXP_W{1'b1}}, 1'b1, op_b[MAN_W-2:0]};
        end else if ((ua.is_zero && ub.is_inf) || (ua.is_inf && ub.is_zero)) begin
            res_c = DFLT_NAN;
        end else if (ua.is_inf || ub.is_inf) begin
            res_c = {psign, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
        end else if (ua.is_zero || ub.is_zero) begin
            res_c = {psign, {(WORD_W-1){1'b0}}};
        end else begin
            res_c = fin_word;
        end
    end

    if (OUT_REG) begin : g_reg
        logic [WORD_W-1:0] res_q;
        // Capture the product, cleared by synchronous reset
        always_ff @(posedge clk) begin
            if (!rst_n) res_q <= '0;
            else        res_q <= res_c;
        end
        assign result = res_q;
    end else begin : g_comb
        assign result = res_c;
    end
endmodule

// File: rtl/hmul16_chk.sv
// hmul16_chk: property checker for hmul16_core. It keeps its own copy of
// the operands aligned with the output latency and checks the special-value
// rules, the sign of finite products and the reset value.
module hmul16_chk #(
    parameter bit OUT_REG = 1'b1
) (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] op_a,
    input logic [15:0] op_b,
    input logic [15:0] result
);
    logic [15:0] a_d;
    logic [15:0] b_d;
    logic        primed;

    // Operand copies matching the registered output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_d    <= '0;
            b_d    <= '0;
            primed <= 1'b0;
        end else begin
            a_d    <= op_a;
            b_d    <= op_b;
            primed <= 1'b1;
        end
    end

    logic [15:0] sa;
    logic [15:0] sb;
    logic        live;
    assign sa   = OUT_REG ? a_d : op_a;
    assign sb   = OUT_REG ? b_d : op_b;
    assign live = OUT_REG ? primed : 1'b1;

    logic a_nan, b_nan, a_inf, b_inf, a_zro, b_zro, any_nan, sgn;
    assign a_nan   = (sa[14:10] == 5'h1f) && (sa[9:0] != 0);
    assign b_nan   = (sb[14:10] == 5'h1f) && (sb[9:0] != 0);
    assign a_inf   = (sa[14:10] == 5'h1f) && (sa[9:0] == 0);
    assign b_inf   = (sb[14:10] == 5'h1f) && (sb[9:0] == 0);
    assign a_zro   = (sa[14:0] == 0);
    assign b_zro   = (sb[14:0] == 0);
    assign any_nan = a_nan || b_nan;
    assign sgn     = sa[15] ^ sb[15];

    assert_nan_a_R1: assert property (@(posedge clk) disable iff (!rst_n)
        live && a_nan |-> result == {sa[15], 5'h1f, 1'b1, sa[8:0]});

    assert_nan_b_R2: assert property (@(posedge clk) disable iff (!rst_n)
        live && !a_nan && b_nan |-> result == {sb[15], 5'h1f, 1'b1, sb[8:0]});

    assert_zero_inf_R3: assert property (@(posedge clk) disable iff (!rst_n)
        live && !any_nan && ((a_zro && b_inf) || (a_inf && b_zro)) |-> result == 16'h7E00);

    assert_inf_out_R4: assert property (@(posedge clk) disable iff (!rst_n)
        live && !any_nan && !a_zro && !b_zro && (a_inf || b_inf) |-> result == {sgn, 15'h7C00});

    assert_zero_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
        live && !any_nan && !a_inf && !b_inf && (a_zro || b_zro) |-> result == {sgn, 15'h0});

    assert_finite_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
        live && !any_nan && !a_inf && !b_inf && !a_zro && !b_zro
        |-> result[15] == sgn && !((result[14:10] == 5'h1f) && (result[9:0] != 0)));

    if (OUT_REG) begin : g_rst
        assert_reset_clear_R10: assert property (@(posedge clk)
            !rst_n |=> result == 16'h0000);
    end
endmodule

bind hmul16_core hmul16_chk #(.OUT_REG(OUT_REG)) u_hmul16_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .op_a   (op_a),
    .op_b   (op_b),
    .result (result)
);

// File: tb/hmul16_core_test.sv
`timescale 1ns/1ps
module hmul16_core_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] op_a = 16'h0;
    logic [15:0] op_b = 16'h0;
    logic [15:0] result;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    hmul16_core #(.OUT_REG(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .result(result)
    );

    // Exact-integer reference: value = sigx*sigy * 2^(ex+ey-20)
    function automatic logic [15:0] ref_mul(input logic [15:0] x, input logic [15:0] y);
        logic sg;
        logic xn, yn, xi, yi, xz, yz;
        longint unsigned sx, sy, p, q, rem, hv;
        int ex, ey, e, qe, s, m;
        sg = x[15] ^ y[15];
        xn = (x[14:10] == 5'h1f) && (x[9:0] != 0);
        yn = (y[14:10] == 5'h1f) && (y[9:0] != 0);
        xi = (x[14:10] == 5'h1f) && (x[9:0] == 0);
        yi = (y[14:10] == 5'h1f) && (y[9:0] == 0);
        xz = (x[14:0] == 0);
        yz = (y[14:0] == 0);
        if (xn) return {x[15], 5'h1f, 1'b1, x[8:0]};
        if (yn) return {y[15], 5'h1f, 1'b1, y[8:0]};
        if ((xz && yi) || (xi && yz)) return 16'h7E00;
        if (xi || yi) return {sg, 15'h7C00};
        if (xz || yz) return {sg, 15'h0};
        sx = (x[14:10] != 0) ? (64'd1024 + x[9:0]) : 64'(x[9:0]);
        sy = (y[14:10] != 0) ? (64'd1024 + y[9:0]) : 64'(y[9:0]);
        ex = (x[14:10] != 0) ? int'(x[14:10]) - 15 : -14;
        ey = (y[14:10] != 0) ? int'(y[14:10]) - 15 : -14;
        p  = sx * sy;
        m  = 0;
        for (int i = 0; i < 64; i++) if (p[i]) m = i;
        e  = ex + ey - 20 + m;
        if (e < -14) e = -14;
        qe = e - 10;
        s  = qe - (ex + ey - 20);
        if (s > 0) begin
            q   = p >> s;
            rem = p & ((64'd1 << s) - 1);
            hv  = 64'd1 << (s - 1);
            if (rem > hv || (rem == hv && q[0])) q = q + 1;
        end else begin
            q = p << (-s);
        end
        if (q == 64'd2048) begin
            q = 64'd1024;
            e = e + 1;
        end
        if (e > 15) return {sg, 15'h7C00};
        if (q < 64'd1024) return {sg, 5'h0, q[9:0]};
        return {sg, 5'(e + 15), q[9:0]};
    endfunction

    // Requirement tag for a random or directed pair
    function automatic string tag_of(input logic [15:0] x, input logic [15:0] y, input logic [15:0] r);
        if ((x[14:10] == 5'h1f) && (x[9:0] != 0)) return "R1";
        if ((y[14:10] == 5'h1f) && (y[9:0] != 0)) return "R2";
        if (r == 16'h7E00) return "R3";
        if (x[14:10] == 5'h1f || y[14:10] == 5'h1f) return "R4";
        if (x[14:0] == 0 || y[14:0] == 0) return "R5";
        if (r[14:10] == 5'h1f) return "R7";
        if (r[14:0] == 0) return "R11";
        if (r[14:10] == 0) return "R8";
        if (x[14:10] == 0 || y[14:10] == 0) return "R9";
        return "R6";
    endfunction

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Drive a pair, wait one edge, compare against a stated value
    task automatic try_pair(input string tag, input logic [15:0] x, input logic [15:0] y, input logic [15:0] exp);
        @(negedge clk);
        op_a = x;
        op_b = y;
        @(negedge clk);
        check(tag, result, exp);
        check(tag, result, ref_mul(x, y));
    endtask

    function automatic logic [15:0] rand_opnd();
        logic [15:0] w;
        int k;
        w = 16'($urandom);
        k = int'($urandom % 8);
        case (k)
            4: w[14:10] = 5'h0;
            5: w[14:10] = 5'(28 + $urandom % 3);
            6: w[14:10] = 5'(1 + $urandom % 4);
            7: begin
                case ($urandom % 3)
                    0: w[14:0] = 15'h0;
                    1: w[14:0] = 15'h7C00;
                    default: w[14:10] = 5'h1f;
                endcase
            end
            default: ;
        endcase
        return w;
    endfunction

    initial begin
        #500000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] x, y, e;
        void'($urandom(32'd20240517));
        // R10: reset clears the output even with live operands
        op_a = 16'h4000;
        op_b = 16'h4200;
        repeat (3) @(negedge clk);
        check("R10 reset", result, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 first", result, 16'h4600);
        // R10: new operands do not reach the output before the edge
        op_a = 16'h3C00;
        op_b = 16'h4400;
        #1;
        check("R10 hold", result, 16'h4600);
        @(negedge clk);
        check("R10 latency", result, 16'h4400);

        try_pair("R1", 16'h7E01, 16'h3C00, 16'h7E01);
        try_pair("R1", 16'hFC01, 16'h3C00, 16'hFE01);
        try_pair("R1", 16'h7D00, 16'h7E77, 16'h7F00);
        try_pair("R2", 16'h3C00, 16'h7C05, 16'h7E05);
        try_pair("R2", 16'h0000, 16'hFD55, 16'hFF55);
        try_pair("R3", 16'h0000, 16'h7C00, 16'h7E00);
        try_pair("R3", 16'hFC00, 16'h8000, 16'h7E00);
        try_pair("R4", 16'hFC00, 16'h4000, 16'hFC00);
        try_pair("R4", 16'h7C00, 16'h8001, 16'hFC00);
        try_pair("R5", 16'h8000, 16'h3C00, 16'h8000);
        try_pair("R5", 16'h8000, 16'h8400, 16'h0000);
        try_pair("R6", 16'h3E00, 16'h3E00, 16'h4080);
        try_pair("R6 tie odd", 16'h3C01, 16'h3E00, 16'h3E02);
        try_pair("R6 tie even", 16'h3C03, 16'h3E00, 16'h3E04);
        try_pair("R7", 16'h7BFF, 16'h7BFF, 16'h7C00);
        try_pair("R7", 16'hDC00, 16'h5C00, 16'hFC00);
        try_pair("R7 edge", 16'h7BFF, 16'h3C00, 16'h7BFF);
        try_pair("R7 round", 16'h7BFF, 16'h3C01, 16'h7C00);
        try_pair("R8", 16'h0400, 16'h3800, 16'h0200);
        try_pair("R8 tie even", 16'h0401, 16'h3800, 16'h0200);
        try_pair("R8 tie odd", 16'h0403, 16'h3800, 16'h0202);
        try_pair("R8 promote", 16'h03FF, 16'h3C01, 16'h0400);
        try_pair("R9", 16'h0001, 16'h6400, 16'h0400);
        try_pair("R9", 16'h03FF, 16'h4000, 16'h07FE);
        try_pair("R11", 16'h0001, 16'h0001, 16'h0000);
        try_pair("R11", 16'h8001, 16'h0001, 16'h8000);
        try_pair("R11 tie", 16'h0001, 16'h3800, 16'h0000);
        try_pair("R11 above", 16'h0001, 16'h3801, 16'h0001);
        try_pair("R11 above", 16'h0001, 16'h3A00, 16'h0001);

        for (int i = 0; i < 4000; i++) begin
            x = rand_opnd();
            y = rand_opnd();
            e = ref_mul(x, y);
            @(negedge clk);
            op_a = x;
            op_b = y;
            @(negedge clk);
            check(tag_of(x, y, e), result, e);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule